// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside a CPU's instruction sequencer. It turns the level-sensitive non-maskable interrupt line into a rising-edge event and keeps that event in a pending latch. It also decides, once per instruction, whether the next instruction slot is replaced by the seven-cycle interrupt entry sequence. The instruction sequencer marks the next-to-last cycle of every instruction. At that point the block looks at the pending NMI, the IRQ level and the interrupt-disable flag. If an interrupt wins, the block raises a take request during the instruction's last cycle and starts the sequence on the cycle after. A decoded software break starts the same sequence through its own input.

While a sequence runs, the block reports the step index. It selects which byte is pushed on each push step, flags the break bit on the status push, and gives the vector fetch address for the low and high byte. It also pulses a request to set the interrupt-disable flag. An NMI edge that arrives during the first four steps of an IRQ or break sequence redirects that sequence to the NMI vector. A later edge stays pending for the next instruction boundary.

Top module: `intr_entry_ctrl`

## Requirements
- R1: After a synchronous reset every output is 0 and no NMI is pending.
- R2: A rising edge of `nmi_in` (1 this cycle, 0 the cycle before) produces at most one NMI sequence. Holding the line high does not produce another.
- R3: Polling happens only in a cycle with `penult_in`=1 while no sequence is running and no take is outstanding. `take_o` is high for exactly the one cycle after such a poll. `penult_in` in any other cycle has no effect.
- R4: At a poll, an IRQ is taken only if `irq_in`=1 and `imask_in`=0. A pending NMI, or an NMI edge in the poll cycle itself, is taken whatever the mask is, and it selects the NMI vector even when an IRQ is also requested.
- R5: A sequence starts in the cycle after `take_o`. While it runs, `seq_busy_o`=1 for exactly 7 cycles and `seq_idx_o` counts 0 to 6. Outside a sequence both are 0.
- R6: An NMI edge seen in steps 0 to 3 of an IRQ or break sequence switches it to the NMI vector. So does an NMI that is still pending when the sequence starts.
- R7: An NMI edge in step 4 or later leaves the running sequence's vector unchanged. The NMI stays pending and is taken at the next poll.
- R8: A sequence that uses the NMI vector consumes every NMI edge seen up to the end of its step 3. No further take follows from those edges.
- R9: `vec_rd_o` is 1 in steps 5 and 6. `vec_addr_o` is then the vector base in step 5 and base+1 in step 6, with base 0xFFFA for NMI and 0xFFFE for IRQ or break. At all other times `vec_addr_o` is 0.
- R10: `push_sel_o` is one-hot: 3'b001 (PC high) in step 2, 3'b010 (PC low) in step 3, 3'b100 (status) in step 4, and 3'b000 otherwise. `push_brk_o` is 1 only in step 4 of a break sequence.
- R11: `imask_set_o` is a one-cycle pulse in step 5, after the status push.
- R12: `brk_in`=1 in a cycle with no sequence running starts a sequence in the next cycle without raising `take_o`. Its vector is 0xFFFE unless step 0 to 3 redirects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | NMI line level (active high) |
| irq_in | input | 1 | IRQ line level (active high) |
| imask_in | input | 1 | Interrupt-disable flag from the status register |
| penult_in | input | 1 | Current cycle is the next-to-last of an instruction |
| brk_in | input | 1 | Break decoded; its entry sequence starts next cycle |
| take_o | output | 1 | Next instruction slot becomes an interrupt entry |
| seq_busy_o | output | 1 | Entry sequence running |
| seq_idx_o | output | 3 | Step index within the sequence |
| push_sel_o | output | 3 | One-hot push select: PC high, PC low, status |
| push_brk_o | output | 1 | Break bit value for the status push |
| vec_rd_o | output | 1 | Vector byte fetch this cycle |
| vec_addr_o | output | 16 | Vector fetch address |
| imask_set_o | output | 1 | Set the interrupt-disable flag |

## Verification
The bench builds the block with its default 16-bit address and the standard vector bases, so every vector address can be checked as a literal value. With a fixed poll cycle, it sweeps the NMI rising edge across every cycle offset from before the poll to past the end of the sequence, for both an IRQ entry and a break entry. This puts both sides of the step-3 redirect boundary within reach, together with the pending carry-over to a later poll. Short runs cover every IRQ and mask combination, NMI priority, a marker held high across a whole sequence, and an interrupt held off because no poll came.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  // Sequence length and step positions; the positions fix the bus order.
  localparam int unsigned SEQ_LEN         = 7;
  localparam int unsigned IDX_W           = $clog2(SEQ_LEN);
  localparam int unsigned STEP_PCH        = 2;
  localparam int unsigned STEP_PCL        = 3;
  localparam int unsigned STEP_STAT       = 4;
  localparam int unsigned STEP_VLO        = 5;
  localparam int unsigned STEP_VHI        = 6;
  localparam int unsigned STEP_HIJACK_END = 3;

  typedef enum logic [2:0] {
    PUSH_NONE = 3'b000,
    PUSH_PCH  = 3'b001,
    PUSH_PCL  = 3'b010,
    PUSH_STAT = 3'b100
  } push_e;

  function automatic push_e step_push(input logic [IDX_W-1:0] step);
    if (step == IDX_W'(STEP_PCH))       return PUSH_PCH;
    else if (step == IDX_W'(STEP_PCL))  return PUSH_PCL;
    else if (step == IDX_W'(STEP_STAT)) return PUSH_STAT;
    else                                return PUSH_NONE;
  endfunction

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic consume,
  output logic pend_any
);

  logic prev_q;
  logic pend_q;
  logic edge_det;

  assign edge_det = nmi_in & ~prev_q;
  assign pend_any = edge_det | pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_in;
      if (consume)       pend_q <= 1'b0;
      else if (edge_det) pend_q <= 1'b1;
    end
  end

  // R2: a detected edge cannot repeat on the very next cycle
  p_one_shot_r2: assert property (@(posedge clk) disable iff (rst)
    edge_det |=> !edge_det);

  // R8: a consume clears the latch whatever arrives in the same cycle
  p_consume_clears_r8: assert property (@(posedge clk) disable iff (rst)
    consume |=> !pend_q);

endmodule

// File: rtl/intr_poll.sv
module intr_poll (
  input  logic clk,
  input  logic rst,
  input  logic poll_en,
  input  logic pend_any,
  input  logic irq_in,
  input  logic imask_in,
  output logic take_q,
  output logic take_nmi_q
);

  logic irq_ok;
  assign irq_ok = irq_in & ~imask_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q     <= 1'b0;
      take_nmi_q <= 1'b0;
    end else begin
      take_q     <= poll_en & (pend_any | irq_ok);
      take_nmi_q <= poll_en & pend_any;
    end
  end

  // R4: an NMI choice never appears without a take
  p_nmi_needs_take_r4: assert property (@(posedge clk) disable iff (rst)
    take_nmi_q |-> take_q);

endmodule

// File: rtl/entry_seq.sv
module entry_seq
  import intr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 'hFFFA,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_int,
  input  logic              start_nmi,
  input  logic              start_brk,
  input  logic              pend_any,
  output logic              busy_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [2:0]        push_o,
  output logic              push_brk_o,
  output logic              vec_rd_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              imask_set_o,
  output logic              consume_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

  logic             busy_q, busy_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             vnmi_q, vnmi_n;
  logic             brk_q, brk_n;
  logic             fetch_n;
  push_e            push_q;

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    vnmi_n = vnmi_q;
    brk_n  = brk_q;
    if (busy_q) begin
      if ((idx_q <= IDX_W'(STEP_HIJACK_END)) && pend_any) vnmi_n = 1'b1;
      if (idx_q == LAST_IDX) begin
        busy_n = 1'b0;
        idx_n  = '0;
        vnmi_n = 1'b0;
        brk_n  = 1'b0;
      end else begin
        idx_n = idx_q + 1'b1;
      end
    end else if (start_int || start_brk) begin
      busy_n = 1'b1;
      idx_n  = '0;
      vnmi_n = start_int & start_nmi;
      brk_n  = start_brk & ~start_int;
    end
  end

  assign consume_o = busy_q && (idx_q == IDX_W'(STEP_HIJACK_END)) && vnmi_n;
  assign fetch_n   = busy_n && ((idx_n == IDX_W'(STEP_VLO)) || (idx_n == IDX_W'(STEP_VHI)));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      idx_q       <= '0;
      vnmi_q      <= 1'b0;
      brk_q       <= 1'b0;
      push_q      <= PUSH_NONE;
      push_brk_o  <= 1'b0;
      vec_rd_o    <= 1'b0;
      vec_addr_o  <= '0;
      imask_set_o <= 1'b0;
    end else begin
      busy_q      <= busy_n;
      idx_q       <= idx_n;
      vnmi_q      <= vnmi_n;
      brk_q       <= brk_n;
      push_q      <= busy_n ? step_push(idx_n) : PUSH_NONE;
      push_brk_o  <= busy_n && (idx_n == IDX_W'(STEP_STAT)) && brk_n;
      vec_rd_o    <= fetch_n;
      vec_addr_o  <= fetch_n ? ((vnmi_n ? NMI_VEC : IRQ_VEC) + ADDR_W'(idx_n == IDX_W'(STEP_VHI)))
                             : '0;
      imask_set_o <= busy_n && (idx_n == IDX_W'(STEP_VLO));
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign push_o = push_q;

  // R5: the step index advances by one while the sequence runs
  p_step_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q != LAST_IDX) |=> (busy_q && idx_q == $past(idx_q) + 1'b1));

  // R5: the last step ends the sequence
  p_step_end_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q == LAST_IDX) |=> !busy_q);

  // R10: PC low is pushed right after PC high
  p_push_order_r10: assert property (@(posedge clk) disable iff (rst)
    (push_q == PUSH_PCL) |-> ($past(push_q) == PUSH_PCH));

  // R9: the high vector byte follows the low byte at the next address
  p_vec_pair_r9: assert property (@(posedge clk) disable iff (rst)
    (vec_rd_o && $past(vec_rd_o)) |-> (vec_addr_o == $past(vec_addr_o) + 1'b1));

  // R11: the mask is set only after the status push
  p_mask_after_push_r11: assert property (@(posedge clk) disable iff (rst)
    imask_set_o |-> ($past(push_q) == PUSH_STAT));

endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 'hFFFA,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_in,
  input  logic              irq_in,
  input  logic              imask_in,
  input  logic              penult_in,
  input  logic              brk_in,
  output logic              take_o,
  output logic              seq_busy_o,
  output logic [IDX_W-1:0]  seq_idx_o,
  output logic [2:0]        push_sel_o,
  output logic              push_brk_o,
  output logic              vec_rd_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              imask_set_o
);

  logic pend_any;
  logic consume;
  logic take_nmi;
  logic poll_en;

  assign poll_en = penult_in & ~seq_busy_o & ~take_o & ~brk_in;

  nmi_edge_latch u_edge (
    .clk      (clk),
    .rst      (rst),
    .nmi_in   (nmi_in),
    .consume  (consume),
    .pend_any (pend_any)
  );

  intr_poll u_poll (
    .clk        (clk),
    .rst        (rst),
    .poll_en    (poll_en),
    .pend_any   (pend_any),
    .irq_in     (irq_in),
    .imask_in   (imask_in),
    .take_q     (take_o),
    .take_nmi_q (take_nmi)
  );

  entry_seq #(
    .ADDR_W  (ADDR_W),
    .NMI_VEC (NMI_VEC),
    .IRQ_VEC (IRQ_VEC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_int   (take_o),
    .start_nmi   (take_nmi),
    .start_brk   (brk_in),
    .pend_any    (pend_any),
    .busy_o      (seq_busy_o),
    .idx_o       (seq_idx_o),
    .push_o      (push_sel_o),
    .push_brk_o  (push_brk_o),
    .vec_rd_o    (vec_rd_o),
    .vec_addr_o  (vec_addr_o),
    .imask_set_o (imask_set_o),
    .consume_o   (consume)
  );

  // R3: a take only ever follows a next-to-last-cycle marker
  p_take_after_poll_r3: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(penult_in));

  // R5: a take is followed by step 0 of the sequence
  p_take_starts_r5: assert property (@(posedge clk) disable iff (rst)
    take_o |=> (seq_busy_o && seq_idx_o == '0));

endmodule

// File: tb/intr_entry_ctrl_test.sv
module intr_entry_ctrl_test;

  localparam logic [15:0] NMIV = 16'hFFFA;
  localparam logic [15:0] IRQV = 16'hFFFE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi = 1'b0, irq = 1'b0, imask = 1'b0, penult = 1'b0, brk = 1'b0;
  logic        take, busy, pbrk, vrd, mset;
  logic [2:0]  idx, psel;
  logic [15:0] vaddr;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  intr_entry_ctrl uut (
    .clk(clk), .rst(rst), .nmi_in(nmi), .irq_in(irq), .imask_in(imask),
    .penult_in(penult), .brk_in(brk), .take_o(take), .seq_busy_o(busy),
    .seq_idx_o(idx), .push_sel_o(psel), .push_brk_o(pbrk), .vec_rd_o(vrd),
    .vec_addr_o(vaddr), .imask_set_o(mset)
  );

  task automatic chk(input string msg, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", msg, got, exp);
    end
  endtask

  // Expected outputs for cycle c from up to two sequences (start sa/sb) and two takes (ta/tb).
  task automatic expect_outs(input int c, input int sa, input logic [15:0] va, input bit ba,
                             input int ta, input int sb, input logic [15:0] vb, input bit bb,
                             input int tb, input string tag);
    bit act = 0;
    int i = 0;
    logic [15:0] v = 16'h0;
    bit b = 0;
    logic [2:0] ep;
    logic [15:0] ev;
    if (sa >= 0 && c >= sa && c <= sa + 6) begin act = 1; i = c - sa; v = va; b = ba; end
    else if (sb >= 0 && c >= sb && c <= sb + 6) begin act = 1; i = c - sb; v = vb; b = bb; end
    ep = !act ? 3'b000 : (i == 2) ? 3'b001 : (i == 3) ? 3'b010 : (i == 4) ? 3'b100 : 3'b000;
    ev = (act && (i == 5)) ? v : (act && (i == 6)) ? v + 16'd1 : 16'h0;
    chk($sformatf("R3 %s take c%0d", tag, c), 32'(take), 32'((c == ta) || (c == tb)));
    chk($sformatf("R5 %s busy c%0d", tag, c), 32'(busy), 32'(act));
    chk($sformatf("R5 %s idx c%0d", tag, c), 32'(idx), act ? 32'(i) : 32'd0);
    chk($sformatf("R10 %s push c%0d", tag, c), 32'(psel), 32'(ep));
    chk($sformatf("R10 %s brkbit c%0d", tag, c), 32'(pbrk), 32'(act && i == 4 && b));
    chk($sformatf("R9 %s vrd c%0d", tag, c), 32'(vrd), 32'(act && (i == 5 || i == 6)));
    chk($sformatf("R9 %s vaddr c%0d", tag, c), 32'(vaddr), 32'(ev));
    chk($sformatf("R11 %s imask c%0d", tag, c), 32'(mset), 32'(act && i == 5));
  endtask

  // Drive one scenario cycle by cycle; inputs change and outputs are sampled at the falling edge.
  task automatic run(input string tag, input int ncyc, input int pa, input int pb,
                     input int plo, input int phi, input int irq_until, input bit msk,
                     input int nmi_at, input int brk_at,
                     input int sa, input logic [15:0] va, input bit ba, input int ta,
                     input int sb, input logic [15:0] vb, input bit bb, input int tb);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      expect_outs(c, sa, va, ba, ta, sb, vb, bb, tb, tag);
      penult = (c == pa) || (c == pb) || (c >= plo && c <= phi);
      irq    = (c <= irq_until);
      imask  = msk;
      nmi    = (nmi_at >= 0) && (c >= nmi_at);
      brk    = (c == brk_at);
    end
    @(negedge clk);
    penult = 0; irq = 0; imask = 0; nmi = 0; brk = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 take", 32'(take), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 idx", 32'(idx), 0);
    chk("R1 push", 32'(psel), 0);
    chk("R1 vaddr", 32'(vaddr), 0);
    chk("R1 vrd/mset/pbrk", 32'({vrd, mset, pbrk}), 0);
    repeat (2) @(negedge clk);

    // IRQ entry with an NMI edge swept from 2 cycles before the poll (P=4) to past the end.
    // Offsets up to 5 land in steps 0-3 (R6, R8); later ones stay pending (R7), held level (R2).
    for (int e = -2; e <= 9; e++) begin
      if (e <= 5)
        run($sformatf("irq sweep %0d R6 R8 R2", e), 30, 4, 16, -1, -2, 4, 0, 4 + e, -1,
            6, (e <= 0) ? NMIV : NMIV, 0, 5, -1, IRQV, 0, -1);
      else
        run($sformatf("irq sweep %0d R7 R2", e), 30, 4, 16, -1, -2, 4, 0, 4 + e, -1,
            6, IRQV, 0, 5, 18, NMIV, 0, 17);
    end

    // Break entry at B=4 with an NMI edge swept; offsets up to 4 hit steps 0-3 (R12, R6).
    for (int e = -2; e <= 7; e++) begin
      if (e <= 4)
        run($sformatf("brk sweep %0d R12 R6", e), 30, -1, 16, -1, -2, -1, 0, 4 + e, 4,
            5, NMIV, 1, -1, -1, IRQV, 0, -1);
      else
        run($sformatf("brk sweep %0d R12 R7", e), 30, -1, 16, -1, -2, -1, 0, 4 + e, 4,
            5, IRQV, 1, -1, 18, NMIV, 0, 17);
    end

    // R4: IRQ level and mask combinations, NMI priority and NMI ignoring the mask
    run("irq open R4", 16, 4, -1, -1, -2, 4, 0, -1, -1, 6, IRQV, 0, 5, -1, IRQV, 0, -1);
    run("irq masked R4", 16, 4, -1, -1, -2, 4, 1, -1, -1, -1, IRQV, 0, -1, -1, IRQV, 0, -1);
    run("irq low R4", 16, 4, -1, -1, -2, -1, 0, -1, -1, -1, IRQV, 0, -1, -1, IRQV, 0, -1);
    run("nmi over irq R4", 16, 4, -1, -1, -2, 4, 0, 4, -1, 6, NMIV, 0, 5, -1, IRQV, 0, -1);
    run("nmi masked R4", 16, 4, -1, -1, -2, 4, 1, 3, -1, 6, NMIV, 0, 5, -1, IRQV, 0, -1);

    // R3: marker held through the take cycle and the whole sequence gives one take only
    run("marker held R3", 16, -1, -1, 4, 12, 12, 0, -1, -1, 6, IRQV, 0, 5, -1, IRQV, 0, -1);

    // R3 R7: pending NMI and IRQ wait with no marker, then the poll at 14 takes the NMI
    run("no poll R3 R7", 26, -1, 14, -1, -2, 12, 0, 3, -1, 16, NMIV, 0, 15, -1, IRQV, 0, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule